// File: doc/BRIEF.md
# Processor Status Word Unit

This block keeps a processor's 16-bit status word. After an 8-bit or 16-bit arithmetic or logic operation, the datapath gives the block the result, the top bit of each operand, the carry out of the top bit and the carry out of bit 3. For each status flag, a per-flag load enable chooses between taking the freshly computed value and keeping the old one. The three control flags (single-step trap, interrupt enable and string direction) are changed only through explicit set and clear strobes.

The block also drives the step that string source and destination index pointers add after each element transfer. The direction flag gives the sign of the step, and the operand size gives its magnitude (one for bytes, two for words). A small control module turns the raw enables into a strobe struct, and a datapath module computes and holds the flags.

Top module: `stat_flags_unit`

## Requirements
- R1: After reset `flagWord` reads 0x0002. At all times bit 1 reads 1, and bits 3, 5 and 12 to 15 read 0.
- R2: When `statLoad[0]` is 1, bit 0 (carry) takes `carryTop` at the next rising clock edge.
- R3: When `statLoad[1]` is 1, bit 2 (parity) becomes 1 if `result[7:0]` has an even number of ones and 0 otherwise. Only the low byte counts, for either operand size.
- R4: When `statLoad[2]` is 1, bit 4 (auxiliary carry) takes `carryNib`.
- R5: When `statLoad[3]` is 1, bit 6 (zero) becomes 1 if the result at the selected size is zero. The size is `result[7:0]` when `opWide`=0 and `result[15:0]` when `opWide`=1.
- R6: When `statLoad[4]` is 1, bit 7 (sign) takes the result's top bit at the selected size: bit 7 when `opWide`=0, bit 15 when `opWide`=1.
- R7: When `statLoad[5]` is 1, bit 11 (overflow) becomes 1 exactly when `opAMsb` equals `opBMsb` and the result's top bit at the selected size differs from them. This is the rule for addition.
- R8: A status flag whose `statLoad` bit is 0 keeps its value, whatever the other inputs do.
- R9: `ctlSet`/`ctlClr` bit 0, 1 and 2 set or clear bit 8 (trap), bit 9 (interrupt enable) and bit 10 (direction) respectively at the next edge. If set and clear are both asserted for one flag, set wins. With neither strobe asserted a control flag holds, and status loads never touch control flags.
- R10: `idxStep` is 0x0001 with direction 0 and `opWide`=0, 0x0002 with direction 0 and `opWide`=1, 0xFFFF with direction 1 and `opWide`=0, and 0xFFFE with direction 1 and `opWide`=1. It follows `opWide` combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| result | input | 16 | Operation result |
| opWide | input | 1 | Operand size: 0 byte, 1 word |
| opAMsb | input | 1 | Top bit of first operand at selected size |
| opBMsb | input | 1 | Top bit of second operand at selected size |
| carryTop | input | 1 | Carry out of the top bit |
| carryNib | input | 1 | Carry out of bit 3 |
| statLoad | input | 6 | Load enables: carry, parity, aux, zero, sign, overflow |
| ctlSet | input | 3 | Set strobes: trap, interrupt enable, direction |
| ctlClr | input | 3 | Clear strobes: trap, interrupt enable, direction |
| flagWord | output | 16 | Status word |
| idxStep | output | 16 | Two's-complement string index step |

## Verification
The assertions take the strobes and load enables to be single-cycle and sampled only at rising edges. They also take the set/clear pair reaching the datapath to be already resolved. They assume nothing about the result or operand bits, so any input values are legal. The stimulus changes every input on the falling edge and holds it through the next rising edge. It drops all enables back to zero between scenarios, so each update is seen in isolation.

// File: rtl/stat_flags_pkg.sv
package stat_flags_pkg;
  localparam int FLAG_W = 16;
  localparam int STAT_N = 6;
  localparam int CTL_N  = 3;

  localparam int CF_POS = 0;
  localparam int PF_POS = 2;
  localparam int AF_POS = 4;
  localparam int ZF_POS = 6;
  localparam int SF_POS = 7;
  localparam int TF_POS = 8;
  localparam int IF_POS = 9;
  localparam int DF_POS = 10;
  localparam int OF_POS = 11;

  // status index order inside loadStat
  localparam int S_CARRY = 0;
  localparam int S_PAR   = 1;
  localparam int S_AUX   = 2;
  localparam int S_ZERO  = 3;
  localparam int S_SIGN  = 4;
  localparam int S_OVF   = 5;

  localparam logic [FLAG_W-1:0] FIXED_ONES = 16'h0002;

  typedef struct packed {
    logic [STAT_N-1:0] loadStat;
    logic [CTL_N-1:0]  setCtl;
    logic [CTL_N-1:0]  clrCtl;
  } flagStrb_t;
endpackage

// File: rtl/stat_flags_ctrl.sv
module stat_flags_ctrl
  import stat_flags_pkg::*;
(
  input  logic [STAT_N-1:0] statLoad,
  input  logic [CTL_N-1:0]  ctlSet,
  input  logic [CTL_N-1:0]  ctlClr,
  output flagStrb_t         strb
);
  always_comb begin
    strb.loadStat = statLoad;
    strb.setCtl   = ctlSet;
    // set has priority: a clear is dropped when the same flag is set
    strb.clrCtl   = ctlClr & ~ctlSet;
  end
endmodule

// File: rtl/stat_flags_dp.sv
module stat_flags_dp
  import stat_flags_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagStrb_t         strb,
  input  logic [DATA_W-1:0] result,
  input  logic              opWide,
  input  logic              opAMsb,
  input  logic              opBMsb,
  input  logic              carryTop,
  input  logic              carryNib,
  output logic [FLAG_W-1:0] flagWord,
  output logic [DATA_W-1:0] idxStep
);
  localparam int WORD_BYTES = DATA_W / BYTE_W;

  logic [STAT_N-1:0] statQ, statCalc;
  logic [CTL_N-1:0]  ctlQ;
  logic              resMsb, resZero;
  logic [DATA_W-1:0] stepMag;

  always_comb begin
    resMsb  = opWide ? result[DATA_W-1] : result[BYTE_W-1];
    resZero = opWide ? (result == '0) : (result[BYTE_W-1:0] == '0);
    statCalc[S_CARRY] = carryTop;
    statCalc[S_PAR]   = ~^result[BYTE_W-1:0];
    statCalc[S_AUX]   = carryNib;
    statCalc[S_ZERO]  = resZero;
    statCalc[S_SIGN]  = resMsb;
    statCalc[S_OVF]   = (opAMsb == opBMsb) && (resMsb != opAMsb);
  end

  for (genvar i = 0; i < STAT_N; i++) begin : g_stat
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   statQ[i] <= 1'b0;
      else if (strb.loadStat[i])   statQ[i] <= statCalc[i];
    end
  end

  for (genvar j = 0; j < CTL_N; j++) begin : g_ctl
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 ctlQ[j] <= 1'b0;
      else if (strb.setCtl[j])   ctlQ[j] <= 1'b1;
      else if (strb.clrCtl[j])   ctlQ[j] <= 1'b0;
    end
  end

  always_comb begin
    flagWord         = FIXED_ONES;
    flagWord[CF_POS] = statQ[S_CARRY];
    flagWord[PF_POS] = statQ[S_PAR];
    flagWord[AF_POS] = statQ[S_AUX];
    flagWord[ZF_POS] = statQ[S_ZERO];
    flagWord[SF_POS] = statQ[S_SIGN];
    flagWord[OF_POS] = statQ[S_OVF];
    flagWord[TF_POS] = ctlQ[0];
    flagWord[IF_POS] = ctlQ[1];
    flagWord[DF_POS] = ctlQ[2];
  end

  always_comb begin
    stepMag = opWide ? DATA_W'(WORD_BYTES) : DATA_W'(1);
    idxStep = ctlQ[2] ? (~stepMag + DATA_W'(1)) : stepMag;
  end

  always_comb begin
    if (rstN) AST_SET_CLR_RESOLVED: assert ((strb.setCtl & strb.clrCtl) == '0); // R9
  end

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStat[S_CARRY] |=> $stable(flagWord[CF_POS])); // R8

  AST_OVF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadStat[S_OVF] |=> $stable(flagWord[OF_POS])); // R8

  AST_ZERO_SIGN_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadStat[S_ZERO] && strb.loadStat[S_SIGN]) |=> !(flagWord[ZF_POS] && flagWord[SF_POS])); // R5

  AST_DIR_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.setCtl[2] |=> flagWord[DF_POS]); // R9

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setCtl == '0 && strb.clrCtl == '0) |=> $stable(flagWord[DF_POS:TF_POS])); // R9

  AST_FIXED_BITS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (flagWord[1] && !flagWord[3] && !flagWord[5] && flagWord[15:12] == 4'h0)); // R1

  AST_STEP_SIGN: assert property (@(posedge clk) disable iff (!rstN)
    flagWord[DF_POS] |-> idxStep[DATA_W-1]); // R10
endmodule

// File: rtl/stat_flags_unit.sv
module stat_flags_unit
  import stat_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] result,
  input  logic              opWide,
  input  logic              opAMsb,
  input  logic              opBMsb,
  input  logic              carryTop,
  input  logic              carryNib,
  input  logic [STAT_N-1:0] statLoad,
  input  logic [CTL_N-1:0]  ctlSet,
  input  logic [CTL_N-1:0]  ctlClr,
  output logic [FLAG_W-1:0] flagWord,
  output logic [DATA_W-1:0] idxStep
);
  flagStrb_t strb;

  stat_flags_ctrl u_ctrl (
    .statLoad (statLoad),
    .ctlSet   (ctlSet),
    .ctlClr   (ctlClr),
    .strb     (strb)
  );

  stat_flags_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .result   (result),
    .opWide   (opWide),
    .opAMsb   (opAMsb),
    .opBMsb   (opBMsb),
    .carryTop (carryTop),
    .carryNib (carryNib),
    .flagWord (flagWord),
    .idxStep  (idxStep)
  );
endmodule

// File: tb/tb_stat_flags_unit.sv
`timescale 1ns/1ps
module tb_stat_flags_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] result = '0;
  logic        opWide = 1'b0, opAMsb = 1'b0, opBMsb = 1'b0;
  logic        carryTop = 1'b0, carryNib = 1'b0;
  logic [5:0]  statLoad = '0;
  logic [2:0]  ctlSet = '0, ctlClr = '0;
  logic [15:0] flagWord, idxStep;

  int testCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  stat_flags_unit dut (
    .clk(clk), .rstN(rstN), .result(result), .opWide(opWide),
    .opAMsb(opAMsb), .opBMsb(opBMsb), .carryTop(carryTop), .carryNib(carryNib),
    .statLoad(statLoad), .ctlSet(ctlSet), .ctlClr(ctlClr),
    .flagWord(flagWord), .idxStep(idxStep)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  // drive one cycle on falling edge, sample at next falling edge
  task automatic apply(input logic [15:0] res, input logic wide, input logic a, input logic b,
                       input logic cy, input logic nib, input logic [5:0] ld,
                       input logic [2:0] st, input logic [2:0] cl);
    @(negedge clk);
    result = res; opWide = wide; opAMsb = a; opBMsb = b;
    carryTop = cy; carryNib = nib; statLoad = ld; ctlSet = st; ctlClr = cl;
    @(negedge clk);
    statLoad = '0; ctlSet = '0; ctlClr = '0;
  endtask

  task automatic t_reset();
    opWide = 1'b0;
    #1;
    check("R1 reset word", flagWord, 16'h0002);
    check("R10 reset step byte", idxStep, 16'h0001);
  endtask

  task automatic t_byte_ops();
    // 0x80 byte add, both msb 0: sign, aux, overflow; one bit set -> odd parity
    apply(16'h0080, 0, 0, 0, 0, 1, 6'h3F, 3'b000, 3'b000);
    check("R4 R6 R7 byte add", flagWord, 16'h0892);
    // 0x0100 byte: low byte zero -> zero, even parity; signs differ -> no overflow
    apply(16'h0100, 0, 0, 1, 0, 0, 6'h3F, 3'b000, 3'b000);
    check("R5 R3 byte zero", flagWord, 16'h0046);
    // 0x00FF byte: 8 ones even parity, sign set, carry, aux; a!=b no overflow
    apply(16'h00FF, 0, 1, 0, 1, 1, 6'h3F, 3'b000, 3'b000);
    check("R2 R3 R6 byte ff", flagWord, 16'h0097);
  endtask

  task automatic t_word_ops();
    apply(16'h0000, 1, 1, 1, 1, 0, 6'h3F, 3'b000, 3'b000);
    check("R2 R5 R7 word zero", flagWord, 16'h0847);
    apply(16'h0100, 1, 0, 1, 0, 0, 6'h3F, 3'b000, 3'b000);
    check("R5 R3 word nonzero low byte zero", flagWord, 16'h0006);
    apply(16'h8003, 1, 0, 0, 0, 1, 6'h3F, 3'b000, 3'b000);
    check("R6 R7 R3 word sign", flagWord, 16'h0896);
    opWide = 1'b1;
    #1;
    check("R10 word step up", idxStep, 16'h0002);
  endtask

  task automatic t_mask_hold();
    apply(16'h0000, 1, 1, 1, 1, 0, 6'h3F, 3'b000, 3'b000);   // 0x0847
    apply(16'h0080, 0, 0, 0, 0, 1, 6'h01, 3'b000, 3'b000);   // carry only
    check("R8 only carry loaded", flagWord, 16'h0846);
    apply(16'h00FF, 0, 1, 0, 1, 1, 6'h3F, 3'b000, 3'b000);   // 0x0097
    apply(16'h0000, 1, 0, 0, 0, 0, 6'h00, 3'b000, 3'b000);
    check("R8 no load holds", flagWord, 16'h0097);
  endtask

  task automatic t_ctl();
    apply(16'h0000, 0, 0, 0, 0, 0, 6'h00, 3'b100, 3'b000);
    check("R9 dir set", flagWord, 16'h0497);
    opWide = 1'b0; #1;
    check("R10 byte step down", idxStep, 16'hFFFF);
    opWide = 1'b1; #1;
    check("R10 word step down", idxStep, 16'hFFFE);
    apply(16'h0000, 0, 0, 0, 0, 0, 6'h00, 3'b001, 3'b001);
    check("R9 set wins over clear", flagWord, 16'h0597);
    apply(16'h0000, 0, 0, 0, 0, 0, 6'h3F, 3'b010, 3'b000);
    check("R9 ctl with status load", flagWord, 16'h0746);
    apply(16'h0000, 0, 0, 0, 0, 0, 6'h00, 3'b000, 3'b101);
    check("R9 clear dir trap", flagWord, 16'h0246);
    opWide = 1'b0; #1;
    check("R10 byte step up", idxStep, 16'h0001);
    check("R1 fixed bits", flagWord & 16'hF02A, 16'h0002);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        t_reset();
        t_byte_ops();
        t_word_ops();
        t_mask_hold();
        t_ctl();
      end
      begin
        repeat (5000) @(posedge clk);
        failCnt++;
        testCnt++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule